// File: doc/BRIEF.md
# Asynchronous SRAM cycle controller

This block sits between a clocked system and an 8192 x 8 asynchronous static RAM. Each user request carries one word to read or to write. The block turns it into a strobe sequence that meets the memory's access, pulse and setup limits. It drives a 13-bit address and two chip enables of opposite polarity: one active low and one active high. It also drives an active-low output enable and an active-low write enable. The bidirectional data bus is split into an input, an output and a driver enable, and the pad ring uses these to build the tristate.

All phase lengths are computed at elaboration. Each is the ceiling of a nanosecond limit divided by `CLK_PERIOD_NS`, and never less than one cycle. `SPEED_GRADE` chooses between the 35 ns figures (0) and the 70 ns figures (1). Every operation follows the same path: idle, one setup cycle, then either a read wait or a write pulse, then a recovery phase, then idle again. Writes are controlled by the write enable. The output enable stays high for the whole write. The controller drives the bus only inside the write pulse, and never in its first cycle.

The figures below use the defaults of 5 ns and grade 0. They give a read wait of 7 cycles, a write pulse of 6 cycles, a read recovery of 4 cycles and a write recovery of 1 cycle.

Top module: `sram_ctl`

## Requirements
- R1: While reset is held and after it is released, `req_ready` is 1, `rd_valid` is 0, `mem_ce1_n` is 1, `mem_ce2` is 0, `mem_oe_n` is 1, `mem_we_n` is 1 and `mem_dq_oe` is 0.
- R2: A request is taken on a rising edge where `req_valid` and `req_ready` are both 1 (`req_write` 1 means write). `req_ready` then stays 0 for the whole operation: 12 cycles for a read and 8 cycles for a write at the defaults. Requests presented during that time are not taken.
- R3: Whenever `req_ready` is 1, the memory is deselected (`mem_ce1_n`=1, `mem_ce2`=0), and `mem_oe_n` and `mem_we_n` are both 1.
- R4: A read holds both enables active and `mem_we_n` at 1. `mem_oe_n` is 0 for the read wait of 7 cycles, which comes after one setup cycle. The memory data is captured at the end of the last wait cycle.
- R5: `rd_valid` is high for exactly one cycle per read, and `rd_data` then holds the word last written to that address.
- R6: During a write, `mem_oe_n` stays 1 and `mem_we_n` is 0 for 6 consecutive cycles at the defaults.
- R7: `mem_dq_oe` is 1 only while `mem_we_n` is 0. It is 0 in the first cycle of the write pulse and returns to 0 in the same cycle that `mem_we_n` returns to 1. It is never 1 while the memory may be driving the bus. The data is therefore driven for at least 25 ns before the write ends.
- R8: `mem_addr` and `mem_dq_out` hold the values taken at acceptance for the whole operation. They do not follow changes on the request inputs.
- R9: When the write enable rises, both chip enables are still active, so the write enable is the signal that ends the write.
- R10: After a read, the memory stays deselected for 4 recovery cycles before `req_ready` returns to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle and able to take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 13 | Word address |
| req_wdata | input | 8 | Write data |
| rd_data | output | 8 | Last read word |
| rd_valid | output | 1 | One-cycle strobe marking new `rd_data` |
| mem_addr | output | 13 | Memory address |
| mem_ce1_n | output | 1 | Active-low chip enable |
| mem_ce2 | output | 1 | Active-high chip enable |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_we_n | output | 1 | Active-low write enable |
| mem_dq_out | output | 8 | Data toward the memory |
| mem_dq_oe | output | 1 | Enable for the data-bus driver |
| mem_dq_in | input | 8 | Data from the memory |

## Verification
The bench runs the controller against a cycle-sampled memory model. The model returns a poison byte when a read is sampled before the access and output-enable times have elapsed. It also flags short write pulses, short data setup and bus contention. Writes followed by readbacks at address 0, at address 8191 and at scattered random addresses show whether data goes to the addressed word. Overwrites and back-to-back reads show whether stale captures or lost scoreboard entries occur. A request held valid with changing fields during a busy cycle shows whether the controller takes a second request early or lets the new inputs leak onto the memory address.

// File: rtl/sram_ctl_pkg.sv
`timescale 1ns/1ps
package sram_ctl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_READ_WAIT,
    ST_WRITE_PULSE,
    ST_RECOVER
  } phase_e;

  // cycles needed to cover a nanosecond limit, at least one
  function automatic int ns_to_cycles(input int ns, input int period_ns);
    int c;
    c = (ns + period_ns - 1) / period_ns;
    if (c < 1) c = 1;
    return c;
  endfunction

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

  // grade 0: 35 ns part, grade 1: 70 ns part
  function automatic int t_access_ns(input int grade);
    return (grade == 0) ? 35 : 70;
  endfunction

  function automatic int t_wpulse_ns(input int grade);
    return (grade == 0) ? 25 : 50;
  endfunction

  function automatic int t_dsetup_ns(input int grade);
    return (grade == 0) ? 25 : 30;
  endfunction

  function automatic int t_addr_end_ns(input int grade);
    return (grade == 0) ? 35 : 70;
  endfunction

  // memory output turn-off after deselect / output disable
  function automatic int t_release_ns(input int grade);
    return (grade == 0) ? 20 : 20;
  endfunction

endpackage

// File: rtl/sram_ctl_rst_sync.sv
`timescale 1ns/1ps
module sram_ctl_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sync_q[STAGES-1];

endmodule

// File: rtl/sram_ctl_phase_cnt.sv
`timescale 1ns/1ps
module sram_ctl_phase_cnt #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] count,
  output logic             zero
);

  logic [CNT_W-1:0] count_nxt;
  logic             count_en;

  always_comb begin
    count_en  = load || (count != '0);
    count_nxt = load ? load_val : (count - 1'b1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        count <= '0;
    else if (count_en) count <= count_nxt;
  end

  assign zero = (count == '0);

endmodule

// File: rtl/sram_ctl_fsm.sv
`timescale 1ns/1ps
module sram_ctl_fsm
  import sram_ctl_pkg::*;
#(
  parameter int RD_CYC  = 7,
  parameter int WP_CYC  = 6,
  parameter int RD_RCV  = 4,
  parameter int WR_RCV  = 1,
  parameter int CNT_W   = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_fire,
  input  logic             op_write,
  input  logic             cnt_zero,
  output phase_e           state,
  output logic             cnt_load,
  output logic [CNT_W-1:0] cnt_val,
  output logic             capture
);

  phase_e state_nxt;

  always_comb begin
    state_nxt = state;
    cnt_load  = 1'b0;
    cnt_val   = '0;
    capture   = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (req_fire) state_nxt = ST_SETUP;
      end
      ST_SETUP: begin
        cnt_load = 1'b1;
        if (op_write) begin
          state_nxt = ST_WRITE_PULSE;
          cnt_val   = CNT_W'(WP_CYC - 1);
        end else begin
          state_nxt = ST_READ_WAIT;
          cnt_val   = CNT_W'(RD_CYC - 1);
        end
      end
      ST_READ_WAIT: begin
        if (cnt_zero) begin
          capture   = 1'b1;
          state_nxt = ST_RECOVER;
          cnt_load  = 1'b1;
          cnt_val   = CNT_W'(RD_RCV - 1);
        end
      end
      ST_WRITE_PULSE: begin
        if (cnt_zero) begin
          state_nxt = ST_RECOVER;
          cnt_load  = 1'b1;
          cnt_val   = CNT_W'(WR_RCV - 1);
        end
      end
      ST_RECOVER: begin
        if (cnt_zero) state_nxt = ST_IDLE;
      end
      default: state_nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= state_nxt;
  end

endmodule

// File: rtl/sram_ctl_dpath.sv
`timescale 1ns/1ps
module sram_ctl_dpath #(
  parameter int ADDR_W = 13,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_fire,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              capture,
  input  logic [DATA_W-1:0] mem_dq_in,
  output logic              op_write,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid
);

  // request fields, held for the whole operation
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_write   <= 1'b0;
      mem_addr   <= '0;
      mem_dq_out <= '0;
    end else if (req_fire) begin
      op_write   <= req_write;
      mem_addr   <= req_addr;
      mem_dq_out <= req_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rd_data <= '0;
    else if (capture) rd_data <= mem_dq_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_valid <= 1'b0;
    else        rd_valid <= capture;
  end

endmodule

// File: rtl/sram_ctl.sv
`timescale 1ns/1ps
module sram_ctl
  import sram_ctl_pkg::*;
#(
  parameter int ADDR_W        = 13,
  parameter int DATA_W        = 8,
  parameter int CLK_PERIOD_NS = 5,
  parameter int SPEED_GRADE   = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_ce1_n,
  output logic              mem_ce2,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_in
);

  // phase lengths in cycles
  localparam int RD_CYC = ns_to_cycles(t_access_ns(SPEED_GRADE), CLK_PERIOD_NS);
  // pulse must cover the pulse width, data setup plus the undriven first
  // cycle, and address-to-end less the setup cycle
  localparam int WP_CYC = max3(ns_to_cycles(t_wpulse_ns(SPEED_GRADE), CLK_PERIOD_NS),
                               ns_to_cycles(t_dsetup_ns(SPEED_GRADE), CLK_PERIOD_NS) + 1,
                               ns_to_cycles(t_addr_end_ns(SPEED_GRADE), CLK_PERIOD_NS) - 1);
  localparam int RD_RCV = ns_to_cycles(t_release_ns(SPEED_GRADE), CLK_PERIOD_NS);
  localparam int WR_RCV = 1;
  localparam int CNT_W  = $clog2(max3(RD_CYC, WP_CYC, RD_RCV) + 1);

  logic             rst_n_int;
  phase_e           state;
  logic             req_fire;
  logic             op_write;
  logic             cnt_load;
  logic [CNT_W-1:0] cnt_val;
  logic [CNT_W-1:0] cnt;
  logic             cnt_zero;
  logic             capture;
  logic             chip_on;
  logic             pulse_first;

  sram_ctl_rst_sync #(.STAGES(2)) rst_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  assign req_ready = (state == ST_IDLE);
  assign req_fire  = req_valid && req_ready;

  sram_ctl_fsm #(
    .RD_CYC (RD_CYC),
    .WP_CYC (WP_CYC),
    .RD_RCV (RD_RCV),
    .WR_RCV (WR_RCV),
    .CNT_W  (CNT_W)
  ) fsm_i (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .req_fire (req_fire),
    .op_write (op_write),
    .cnt_zero (cnt_zero),
    .state    (state),
    .cnt_load (cnt_load),
    .cnt_val  (cnt_val),
    .capture  (capture)
  );

  sram_ctl_phase_cnt #(.CNT_W(CNT_W)) cnt_i (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .load     (cnt_load),
    .load_val (cnt_val),
    .count    (cnt),
    .zero     (cnt_zero)
  );

  sram_ctl_dpath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) dpath_i (
    .clk        (clk),
    .rst_n      (rst_n_int),
    .req_fire   (req_fire),
    .req_write  (req_write),
    .req_addr   (req_addr),
    .req_wdata  (req_wdata),
    .capture    (capture),
    .mem_dq_in  (mem_dq_in),
    .op_write   (op_write),
    .mem_addr   (mem_addr),
    .mem_dq_out (mem_dq_out),
    .rd_data    (rd_data),
    .rd_valid   (rd_valid)
  );

  // strobe decode from registered phase; enables stay on one cycle past
  // the write pulse so the write enable ends the write
  always_comb begin
    chip_on = (state == ST_SETUP) || (state == ST_READ_WAIT) ||
              (state == ST_WRITE_PULSE) || ((state == ST_RECOVER) && op_write);
    pulse_first = (cnt == CNT_W'(WP_CYC - 1));
    mem_ce1_n = !chip_on;
    mem_ce2   = chip_on;
    mem_oe_n  = (state != ST_READ_WAIT);
    mem_we_n  = (state != ST_WRITE_PULSE);
    mem_dq_oe = (state == ST_WRITE_PULSE) && !pulse_first;
  end

endmodule

// File: rtl/sram_ctl_chk.sv
`timescale 1ns/1ps
module sram_ctl_chk #(
  parameter int ADDR_W = 13
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              rd_valid,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_ce1_n,
  input logic              mem_ce2,
  input logic              mem_oe_n,
  input logic              mem_we_n,
  input logic              mem_dq_oe
);

  a_r2_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  a_r3_idle_deselected: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (mem_ce1_n && !mem_ce2 && mem_oe_n && mem_we_n));

  a_r5_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid);

  a_r6_oe_off_in_write: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> mem_oe_n);

  a_r7_drive_in_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> !mem_we_n);

  a_r7_no_drive_first: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_we_n) |-> !mem_dq_oe);

  a_r7_release_with_we: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> !mem_dq_oe);

  a_r8_addr_held: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_ready && $past(!req_ready)) |-> $stable(mem_addr));

  a_r9_we_ends_write: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> (!mem_ce1_n && mem_ce2));

endmodule

bind sram_ctl sram_ctl_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .rd_valid  (rd_valid),
  .mem_addr  (mem_addr),
  .mem_ce1_n (mem_ce1_n),
  .mem_ce2   (mem_ce2),
  .mem_oe_n  (mem_oe_n),
  .mem_we_n  (mem_we_n),
  .mem_dq_oe (mem_dq_oe)
);

// File: tb/sram_ctl_tb_top.sv
`timescale 1ns/1ps
module sram_ctl_tb_top;

  localparam int T_NS = 5;

  logic        clk;
  logic        rst_n;
  logic        req_valid;
  logic        req_ready;
  logic        req_write;
  logic [12:0] req_addr;
  logic [7:0]  req_wdata;
  logic [7:0]  rd_data;
  logic        rd_valid;
  logic [12:0] mem_addr;
  logic        mem_ce1_n;
  logic        mem_ce2;
  logic        mem_oe_n;
  logic        mem_we_n;
  logic [7:0]  mem_dq_out;
  logic        mem_dq_oe;
  logic [7:0]  mem_dq_in;

  int checks;
  int errors;
  bit done;

  logic [7:0] ref_mem [int];
  logic [7:0] mdl_mem [int];
  logic [7:0] exp_q [$];

  sram_ctl dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_write  (req_write),
    .req_addr   (req_addr),
    .req_wdata  (req_wdata),
    .rd_data    (rd_data),
    .rd_valid   (rd_valid),
    .mem_addr   (mem_addr),
    .mem_ce1_n  (mem_ce1_n),
    .mem_ce2    (mem_ce2),
    .mem_oe_n   (mem_oe_n),
    .mem_we_n   (mem_we_n),
    .mem_dq_out (mem_dq_out),
    .mem_dq_oe  (mem_dq_oe),
    .mem_dq_in  (mem_dq_in)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // ---------------- memory model, sampled once per cycle ----------------
  int          acc;
  int          oacc;
  int          wl;
  int          dl;
  logic [7:0]  wdat;
  logic [12:0] waddr;
  logic [12:0] last_addr;
  bit          last_sel;
  bit          last_oe;

  initial begin
    acc = 0; oacc = 0; wl = 0; dl = 0;
    wdat = '0; waddr = '0; last_addr = '0; last_sel = 0; last_oe = 0;
    mem_dq_in = 8'hEE;
  end

  always @(negedge clk) begin
    bit sel;
    if (rst_n) begin
      sel = !mem_ce1_n && mem_ce2;
      if (mem_dq_oe && sel && !mem_oe_n) check(0, "R7", "bus contention", 1, 0);
      if (mem_dq_oe && mem_we_n)         check(0, "R7", "drive outside pulse", 1, 0);
      if (sel && !mem_we_n) begin
        wl++;
        if (mem_dq_oe) begin dl++; wdat = mem_dq_out; end
        waddr = mem_addr;
      end else if (wl > 0) begin
        check(sel, "R9", "enables at write end", sel, 1);
        check(wl == 6, "R6", "write pulse cycles", wl, 6);
        check(dl * T_NS >= 25, "R7", "data setup ns", dl * T_NS, 25);
        check(acc * T_NS >= 35, "R8", "address to end ns", acc * T_NS, 35);
        mdl_mem[waddr] = wdat;
        wl = 0; dl = 0;
      end
      if (sel && last_sel && mem_addr == last_addr) acc++;
      else acc = sel ? 1 : 0;
      if (sel && !mem_oe_n && last_oe) oacc++;
      else oacc = (sel && !mem_oe_n) ? 1 : 0;
      last_sel  = sel;
      last_oe   = sel && !mem_oe_n;
      last_addr = mem_addr;
      if (sel && !mem_oe_n && mem_we_n && acc * T_NS >= 35 && oacc * T_NS >= 15)
        mem_dq_in <= mdl_mem.exists(int'(mem_addr)) ? mdl_mem[int'(mem_addr)] : 8'h00;
      else
        mem_dq_in <= 8'hEE;
    end
  end

  // ---------------- scoreboard monitor ----------------
  bit prev_rdv;
  initial prev_rdv = 0;

  always @(negedge clk) begin
    logic [7:0] e;
    if (rst_n) begin
      if (rd_valid && prev_rdv) check(0, "R5", "rd_valid wider than one cycle", 2, 1);
      if (rd_valid) begin
        if (exp_q.size() == 0) check(0, "R5", "unexpected read result", rd_data, 0);
        else begin
          e = exp_q.pop_front();
          check(rd_data == e, "R5", "read data", rd_data, e);
        end
      end
      prev_rdv = rd_valid;
    end
  end

  // ---------------- driver ----------------
  task automatic run_op(input bit wr, input logic [12:0] a, input logic [7:0] d,
                        input bit hold);
    int busy;
    @(negedge clk);
    req_valid = 1; req_write = wr; req_addr = a; req_wdata = d;
    while (!req_ready) @(negedge clk);
    if (wr) ref_mem[int'(a)] = d;
    else exp_q.push_back(ref_mem.exists(int'(a)) ? ref_mem[int'(a)] : 8'h00);
    @(posedge clk);
    @(negedge clk);
    if (hold) begin
      req_addr = ~a; req_wdata = ~d; req_write = !wr;
    end else req_valid = 0;
    busy = 0;
    while (!req_ready) begin
      busy++;
      if (hold) begin
        check(mem_addr == a, "R8", "address held", mem_addr, a);
        if (wr) check(mem_dq_out == d, "R8", "write data held", mem_dq_out, d);
      end
      if (!wr && !mem_ce1_n == 1'b0 && busy > 8)
        check(mem_ce1_n && !mem_ce2, "R10", "deselect in recovery", mem_ce2, 0);
      if (!wr && busy >= 2 && busy <= 8)
        check(!mem_oe_n && mem_we_n, "R4", "read strobes", {mem_oe_n, mem_we_n}, 1);
      if (busy > 40) break;
      @(negedge clk);
    end
    req_valid = 0;
    if (wr) check(busy == 8,  "R2", "write busy cycles", busy, 8);
    else    check(busy == 12, "R10", "read busy cycles", busy, 12);
    check(mem_ce1_n && !mem_ce2 && mem_oe_n && mem_we_n, "R3", "idle strobes",
          {mem_ce1_n, mem_ce2, mem_oe_n, mem_we_n}, 4'b1011);
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    checks = 0; errors = 0; done = 0;
    rst_n = 0; req_valid = 0; req_write = 0; req_addr = '0; req_wdata = '0;
    repeat (5) @(negedge clk);
    check(req_ready && !rd_valid && mem_ce1_n && !mem_ce2 && mem_oe_n && mem_we_n && !mem_dq_oe,
          "R1", "outputs in reset", {req_ready, rd_valid, mem_dq_oe}, 3'b100);
    rst_n = 1;
    repeat (4) @(negedge clk);
    check(req_ready && !rd_valid && mem_ce1_n && !mem_ce2 && !mem_dq_oe,
          "R1", "outputs after reset", {req_ready, rd_valid, mem_dq_oe}, 3'b100);

    // edges of the address range
    run_op(1, 13'h0000, 8'h5A, 0);
    run_op(1, 13'h1FFF, 8'hA5, 0);
    run_op(0, 13'h0000, 8'h00, 0);
    run_op(0, 13'h1FFF, 8'h00, 0);
    // overwrite then read
    run_op(1, 13'h0000, 8'hC3, 0);
    run_op(0, 13'h0000, 8'h00, 0);
    // request held valid during busy cycles (R2, R8)
    run_op(1, 13'h0155, 8'h3C, 1);
    run_op(0, 13'h0155, 8'h00, 1);
    // scattered addresses
    for (int i = 0; i < 10; i++) begin
      logic [12:0] a;
      a = 13'($urandom_range(1, 8190));
      run_op(1, a, 8'($urandom_range(0, 255)), 0);
      run_op(0, a, 8'h00, 0);
    end
    // back-to-back reads
    run_op(0, 13'h1FFF, 8'h00, 0);
    run_op(0, 13'h0155, 8'h00, 0);
    repeat (4) @(negedge clk);
    check(exp_q.size() == 0, "R5", "all reads returned", exp_q.size(), 0);
    done = 1;
    finish_run();
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R2 watchdog expired actual=%0d expected=%0d", 0, 1);
      finish_run();
    end
  end

endmodule